// File: doc/BRIEF.md
# Character Slice Interpolator and Glyph Fetch

This block sits in the pixel path of an on-screen display engine. For every character of a text strip it takes the current scan line within the strip, the programmed strip height and the character code. It rescales the scan line onto one of the 18 fixed slices of a 12x18 glyph and issues a fetch for that slice. User-defined glyphs are fetched from a 1 KB display RAM and built-in glyphs from a ROM port. When the data returns, the block delivers the 12-pixel row for the glyph.

Single-byte modifier codes can be placed in the code stream ahead of a glyph. They mirror or flip the next displayable glyph. Vertical modifiers change which slice is fetched. Horizontal modifiers change the order of the returned pixels. The RAM and ROM contents are outside the block: both answer combinationally to the address the block presents.

Top module: `glyph_slice_fetch`

## Requirements
- R1: One clock edge after a displayable code is sampled with `codeValid`, `fetchValid` is high for one cycle and `fetchSlice` = min(17, floor((36*scanLine + stripHeight) / (2*stripHeight))), which is the rounded value of scanLine*18/stripHeight. A `stripHeight` of 0 gives slice 0, and a scanLine of 0 gives slice 0.
- R2: A computed slice of 18 or more is clamped to 17.
- R3: When `udcEnable`=1 and the code is F0h..FFh, `fetchRam`=1 and `ramAddr` = 64*(code-240) + 2*(slice+7). This is the even byte address of the slice.
- R4: When `udcEnable`=0, or the code is 20h..DFh, `fetchRam`=0 and `romCode` equals the code. Codes F0h..FFh with `udcEnable`=0 go to the ROM.
- R5: Two clock edges after the code, `pixelValid` is high and `pixelRow` holds the fetched row, with bit 11 as the leftmost pixel. A RAM row is {ramHi[3:0], ramLo}, and the upper nibble of `ramHi` is ignored. A ROM row is `romData`.
- R6: Code 03h reverses the pixel order of the next glyph (bit i takes bit 11-i).
- R7: Code 06h fetches slice 17-s instead of slice s. Code 07h applies both 06h and 03h.
- R8: Code 01h mirrors the top half onto the bottom half: a slice s>=9 becomes 17-s. Code 02h mirrors the bottom half onto the top half: a slice s<9 becomes 17-s.
- R9: Code 04h mirrors the left half onto the right half: bits 5..0 take bits 6..11 in reverse. Code 05h mirrors the right half onto the left half: bits 11..6 take bits 0..5 in reverse.
- R10: A modifier code itself causes no fetch. It applies only to the next displayable glyph and is then cleared. A later modifier replaces an earlier pending one.
- R11: Codes 00h, 08h..1Fh and E0h..EFh cause no fetch and leave a pending modifier untouched.
- R12: After reset, `fetchValid` and `pixelValid` are 0 and no modifier is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanLine | input | 6 | Scan line number within the current strip |
| stripHeight | input | 6 | Programmed strip height in scan lines |
| codeIn | input | 8 | Character or modifier code |
| codeValid | input | 1 | codeIn is valid this cycle |
| udcEnable | input | 1 | Fetch codes F0h..FFh from RAM |
| ramLo | input | 8 | RAM even byte at ramAddr (pixels 7..0) |
| ramHi | input | 8 | RAM odd byte at ramAddr+1 (low nibble = pixels 11..8) |
| romData | input | 12 | ROM row for romCode and fetchSlice |
| fetchValid | output | 1 | Fetch address valid this cycle |
| fetchRam | output | 1 | Fetch targets RAM (1) or ROM (0) |
| ramAddr | output | 10 | RAM byte address of the slice's even byte |
| romCode | output | 8 | Code presented to the ROM |
| fetchSlice | output | 5 | Slice index after vertical modifier |
| pixelValid | output | 1 | pixelRow valid this cycle |
| pixelRow | output | 12 | Pixel row, bit 11 leftmost, 1 = foreground |

## Verification
The fetch outputs (`fetchValid`, `fetchRam`, `ramAddr`, `romCode`, `fetchSlice`) are due one rising edge after a code is sampled. The pixel row is due one edge later, because the memory answers combinationally from the registered address. Each scenario task drives a code on a falling edge and holds it for exactly one cycle. It checks the fetch outputs on the next falling edge and the pixel row on the falling edge after that, so every sample lands half a cycle after the edge that produced it. After a modifier or an ignored code, the task checks that `fetchValid` stays low on the falling edge where a fetch would otherwise appear.

// File: rtl/glyph_fetch_pkg.sv
package glyph_fetch_pkg;
  typedef enum logic [1:0] { V_NONE, V_REV, V_TOP, V_BOT } vmode_t;
  typedef enum logic [1:0] { H_NONE, H_REV, H_LEFT, H_RIGHT } hmode_t;

  typedef struct packed {
    logic   fetchStb;
    logic   useRam;
    vmode_t vMode;
    hmode_t hMode;
  } fetch_ctrl_t;
endpackage

// File: rtl/glyph_slice_interp.sv
module glyph_slice_interp #(
  parameter int SCAN_W  = 6,
  parameter int SLICES  = 18,
  parameter int SLICE_W = 5
) (
  input  logic [SCAN_W-1:0]  scanLine,
  input  logic [SCAN_W-1:0]  stripHeight,
  output logic [SLICE_W-1:0] slice
);
  localparam int NUM_W = SCAN_W + $clog2(2*SLICES) + 1;
  localparam logic [NUM_W-1:0] LAST = NUM_W'(SLICES - 1);

  logic [NUM_W-1:0] num, den, quot;

  // rounded scanLine*SLICES/stripHeight = (2*SLICES*s + h) / (2*h)
  always_comb begin
    num  = NUM_W'(scanLine) * NUM_W'(2*SLICES) + NUM_W'(stripHeight);
    den  = NUM_W'(stripHeight) << 1;
    quot = (stripHeight == '0) ? '0 : num / den;
    if (quot > LAST) slice = SLICE_W'(SLICES - 1);
    else             slice = quot[SLICE_W-1:0];
  end
endmodule

// File: rtl/glyph_fetch_ctrl.sv
module glyph_fetch_ctrl
  import glyph_fetch_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              codeValid,
  input  logic              udcEnable,
  output fetch_ctrl_t       ctrl
);
  localparam logic [CODE_W-1:0] ROM_LO = CODE_W'(8'h20);
  localparam logic [CODE_W-1:0] ROM_HI = CODE_W'(8'hDF);
  localparam logic [CODE_W-1:0] UDC_LO = CODE_W'(8'hF0);

  vmode_t pendV;
  hmode_t pendH;
  logic   isGlyph, isUdc, isMod;
  vmode_t modV;
  hmode_t modH;

  always_comb begin
    isUdc   = codeIn >= UDC_LO;
    isGlyph = isUdc || (codeIn >= ROM_LO && codeIn <= ROM_HI);
    isMod   = 1'b1;
    modV    = V_NONE;
    modH    = H_NONE;
    unique case (codeIn)
      CODE_W'(8'h01): modV = V_TOP;
      CODE_W'(8'h02): modV = V_BOT;
      CODE_W'(8'h03): modH = H_REV;
      CODE_W'(8'h04): modH = H_LEFT;
      CODE_W'(8'h05): modH = H_RIGHT;
      CODE_W'(8'h06): modV = V_REV;
      CODE_W'(8'h07): begin modV = V_REV; modH = H_REV; end
      default:        isMod = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendV <= V_NONE;
      pendH <= H_NONE;
    end else if (codeValid && isMod) begin
      pendV <= modV;
      pendH <= modH;
    end else if (codeValid && isGlyph) begin
      pendV <= V_NONE;
      pendH <= H_NONE;
    end
  end

  always_comb begin
    ctrl.fetchStb = codeValid && isGlyph;
    ctrl.useRam   = udcEnable && isUdc;
    ctrl.vMode    = pendV;
    ctrl.hMode    = pendH;
  end

  // R10: a consumed modifier does not outlive its glyph
  assert_mod_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && isGlyph) |=> (pendV == V_NONE && pendH == H_NONE));

  // R11: ignored codes leave the pending modifier as it was
  assert_ignored_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !isGlyph && !isMod) |=> ($stable(pendV) && $stable(pendH)));
endmodule

// File: rtl/glyph_fetch_dp.sv
module glyph_fetch_dp
  import glyph_fetch_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int SLICES  = 18,
  parameter int SLICE_W = 5,
  parameter int GLYPH_W = 12,
  parameter int RAM_AW  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetch_ctrl_t        ctrl,
  input  logic [CODE_W-1:0]  codeIn,
  input  logic [SLICE_W-1:0] rawSlice,
  input  logic [7:0]         ramLo,
  input  logic [7:0]         ramHi,
  input  logic [GLYPH_W-1:0] romData,
  output logic               fetchValid,
  output logic               fetchRam,
  output logic [RAM_AW-1:0]  ramAddr,
  output logic [CODE_W-1:0]  romCode,
  output logic [SLICE_W-1:0] fetchSlice,
  output logic               pixelValid,
  output logic [GLYPH_W-1:0] pixelRow
);
  localparam int HALF_S    = SLICES / 2;
  localparam int HALF_W    = GLYPH_W / 2;
  localparam int HI_BITS   = GLYPH_W - 8;
  localparam int SLOT_BITS = RAM_AW - 4;
  localparam logic [SLICE_W-1:0] LAST = SLICE_W'(SLICES - 1);
  localparam logic [RAM_AW-1:0] SLICE_BASE = RAM_AW'(7);

  logic [SLICE_W-1:0] vSlice;
  logic [RAM_AW-1:0]  nextAddr;
  hmode_t             heldH;
  logic [GLYPH_W-1:0] rawRow, outRow;

  // vertical modifier picks the slice actually fetched
  always_comb begin
    unique case (ctrl.vMode)
      V_REV:   vSlice = LAST - rawSlice;
      V_TOP:   vSlice = (rawSlice >= SLICE_W'(HALF_S)) ? LAST - rawSlice : rawSlice;
      V_BOT:   vSlice = (rawSlice <  SLICE_W'(HALF_S)) ? LAST - rawSlice : rawSlice;
      default: vSlice = rawSlice;
    endcase
    nextAddr = {codeIn[3:0], SLOT_BITS'(0)}
             + ((RAM_AW'(vSlice) + SLICE_BASE) << 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchValid <= 1'b0;
      fetchRam   <= 1'b0;
      ramAddr    <= '0;
      romCode    <= '0;
      fetchSlice <= '0;
      heldH      <= H_NONE;
    end else begin
      fetchValid <= ctrl.fetchStb;
      if (ctrl.fetchStb) begin
        fetchRam   <= ctrl.useRam;
        ramAddr    <= ctrl.useRam ? nextAddr : '0;
        romCode    <= codeIn;
        fetchSlice <= vSlice;
        heldH      <= ctrl.hMode;
      end
    end
  end

  assign rawRow = fetchRam ? {ramHi[HI_BITS-1:0], ramLo} : romData;

  // horizontal modifier reorders the returned pixels
  for (genvar i = 0; i < GLYPH_W; i++) begin : g_hmap
    always_comb begin
      unique case (heldH)
        H_REV:   outRow[i] = rawRow[GLYPH_W-1-i];
        H_LEFT:  outRow[i] = (i < HALF_W)  ? rawRow[GLYPH_W-1-i] : rawRow[i];
        H_RIGHT: outRow[i] = (i >= HALF_W) ? rawRow[GLYPH_W-1-i] : rawRow[i];
        default: outRow[i] = rawRow[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixelValid <= 1'b0;
      pixelRow   <= '0;
    end else begin
      pixelValid <= fetchValid;
      if (fetchValid) pixelRow <= outRow;
    end
  end

  assert_slice_clamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (fetchSlice <= LAST));

  assert_ram_even_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchRam) |-> (ramAddr[0] == 1'b0
      && ramAddr[SLOT_BITS-1:0] >= SLOT_BITS'(2*7)
      && ramAddr[SLOT_BITS-1:0] <= SLOT_BITS'(2*(SLICES-1+7))));

  assert_pixel_timing_R5: assert property (@(posedge clk) disable iff (!rstN)
    pixelValid |-> $past(fetchValid));
endmodule

// File: rtl/glyph_slice_fetch.sv
module glyph_slice_fetch
  import glyph_fetch_pkg::*;
#(
  parameter int SCAN_W  = 6,
  parameter int CODE_W  = 8,
  parameter int SLICES  = 18,
  parameter int GLYPH_W = 12,
  parameter int RAM_AW  = 10,
  localparam int SLICE_W = $clog2(SLICES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SCAN_W-1:0]  scanLine,
  input  logic [SCAN_W-1:0]  stripHeight,
  input  logic [CODE_W-1:0]  codeIn,
  input  logic               codeValid,
  input  logic               udcEnable,
  input  logic [7:0]         ramLo,
  input  logic [7:0]         ramHi,
  input  logic [GLYPH_W-1:0] romData,
  output logic               fetchValid,
  output logic               fetchRam,
  output logic [RAM_AW-1:0]  ramAddr,
  output logic [CODE_W-1:0]  romCode,
  output logic [SLICE_W-1:0] fetchSlice,
  output logic               pixelValid,
  output logic [GLYPH_W-1:0] pixelRow
);
  fetch_ctrl_t        ctrl;
  logic [SLICE_W-1:0] rawSlice;

  glyph_slice_interp #(.SCAN_W(SCAN_W), .SLICES(SLICES), .SLICE_W(SLICE_W)) u_interp (
    .scanLine(scanLine), .stripHeight(stripHeight), .slice(rawSlice));

  glyph_fetch_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .codeValid(codeValid),
    .udcEnable(udcEnable), .ctrl(ctrl));

  glyph_fetch_dp #(.CODE_W(CODE_W), .SLICES(SLICES), .SLICE_W(SLICE_W),
                   .GLYPH_W(GLYPH_W), .RAM_AW(RAM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .codeIn(codeIn), .rawSlice(rawSlice),
    .ramLo(ramLo), .ramHi(ramHi), .romData(romData),
    .fetchValid(fetchValid), .fetchRam(fetchRam), .ramAddr(ramAddr),
    .romCode(romCode), .fetchSlice(fetchSlice),
    .pixelValid(pixelValid), .pixelRow(pixelRow));

  // R1: a fetch appears exactly one edge after a sampled code
  assert_fetch_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> $past(codeValid));
endmodule

// File: tb/glyph_slice_fetch_tb.sv
`timescale 1ns/1ps
module glyph_slice_fetch_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] scanLine = '0, stripHeight = '0;
  logic [7:0] codeIn = '0;
  logic codeValid = 1'b0, udcEnable = 1'b0;
  logic [7:0] ramLo, ramHi;
  logic [11:0] romData;
  logic fetchValid, fetchRam, pixelValid;
  logic [9:0] ramAddr;
  logic [7:0] romCode;
  logic [4:0] fetchSlice;
  logic [11:0] pixelRow;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // memory models answer combinationally to the registered address
  assign ramLo   = ramAddr[7:0] ^ 8'h3C;
  assign ramHi   = {4'hC, ramAddr[9:8], ramAddr[2:1]};
  assign romData = {romCode[2:0], fetchSlice, 4'b1001};

  glyph_slice_fetch u_dut (
    .clk(clk), .rstN(rstN), .scanLine(scanLine), .stripHeight(stripHeight),
    .codeIn(codeIn), .codeValid(codeValid), .udcEnable(udcEnable),
    .ramLo(ramLo), .ramHi(ramHi), .romData(romData),
    .fetchValid(fetchValid), .fetchRam(fetchRam), .ramAddr(ramAddr),
    .romCode(romCode), .fetchSlice(fetchSlice),
    .pixelValid(pixelValid), .pixelRow(pixelRow));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expSlice(input int s, input int ch);
    int v;
    if (ch == 0) return 0;
    v = (36*s + ch) / (2*ch);
    return (v > 17) ? 17 : v;
  endfunction

  function automatic int expV(input int sl, input int md);
    case (md)
      1: return (sl >= 9) ? 17 - sl : sl;
      2: return (sl < 9) ? 17 - sl : sl;
      6, 7: return 17 - sl;
      default: return sl;
    endcase
  endfunction

  function automatic logic [11:0] expH(input logic [11:0] r, input int md);
    logic [11:0] o;
    o = r;
    for (int i = 0; i < 12; i++) begin
      if (md == 3 || md == 7) o[i] = r[11-i];
      if (md == 4 && i < 6)   o[i] = r[11-i];
      if (md == 5 && i >= 6)  o[i] = r[11-i];
    end
    return o;
  endfunction

  // one code for one cycle, driven on a falling edge
  task automatic sendCode(input logic [7:0] c);
    codeIn = c; codeValid = 1'b1;
    @(negedge clk);
    codeValid = 1'b0;
  endtask

  task automatic sendNoFetch(input logic [7:0] c, input string tag);
    sendCode(c);
    check(fetchValid == 1'b0, tag, fetchValid, 0);
  endtask

  // optional modifier, then a glyph; checks fetch and pixel stages
  task automatic runGlyph(input string tag, input int md, input logic [7:0] c,
                          input int s, input int ch, input bit udc);
    int sl;
    bit ram;
    logic [9:0] addr;
    logic [11:0] raw;
    scanLine = 6'(s); stripHeight = 6'(ch); udcEnable = udc;
    if (md != 0) sendNoFetch(8'(md), {tag, " R10 modifier no fetch"});
    sl   = expV(expSlice(s, ch), md);
    ram  = udc && (c >= 8'hF0);
    addr = 10'(64*(c - 8'hF0) + 2*(sl + 7));
    sendCode(c);
    check(fetchValid == 1'b1, {tag, " R1 fetchValid"}, fetchValid, 1);
    check(fetchSlice == 5'(sl), {tag, " R1 slice"}, fetchSlice, sl);
    check(fetchRam == ram, {tag, " R3/R4 select"}, fetchRam, ram);
    if (ram) check(ramAddr == addr, {tag, " R3 ramAddr"}, ramAddr, addr);
    else     check(romCode == c, {tag, " R4 romCode"}, romCode, c);
    raw = ram ? {addr[9:8], addr[2:1], addr[7:0] ^ 8'h3C}
              : {c[2:0], 5'(sl), 4'b1001};
    @(negedge clk);
    check(pixelValid == 1'b1, {tag, " R5 pixelValid"}, pixelValid, 1);
    check(pixelRow == expH(raw, md), {tag, " R5 pixelRow"}, pixelRow, expH(raw, md));
  endtask

  task automatic t_reset;
    check(fetchValid == 1'b0, "R12 reset fetchValid", fetchValid, 0);
    check(pixelValid == 1'b0, "R12 reset pixelValid", pixelValid, 0);
    runGlyph("R12 no pending modifier", 0, 8'h41, 5, 18, 1'b0);
  endtask

  task automatic t_slices;
    runGlyph("R1 identity", 0, 8'h42, 7, 18, 1'b0);
    runGlyph("R1 half height", 0, 8'h43, 4, 9, 1'b0);
    runGlyph("R1 tall strip", 0, 8'h44, 35, 36, 1'b0);
    runGlyph("R1 rounding", 0, 8'h45, 3, 20, 1'b0);
    runGlyph("R1 line zero", 0, 8'h46, 0, 40, 1'b0);
    runGlyph("R1 zero height", 0, 8'h47, 9, 0, 1'b0);
    runGlyph("R2 clamp", 0, 8'h48, 63, 10, 1'b0);
    runGlyph("R2 edge 17/18", 0, 8'h49, 17, 18, 1'b0);
  endtask

  task automatic t_memsel;
    runGlyph("R3 udc first", 0, 8'hF0, 0, 18, 1'b1);
    runGlyph("R3 udc last", 0, 8'hFF, 17, 18, 1'b1);
    runGlyph("R3 udc mid", 0, 8'hF7, 6, 12, 1'b1);
    runGlyph("R4 udc disabled", 0, 8'hF5, 6, 12, 1'b0);
    runGlyph("R4 rom with udc on", 0, 8'hDF, 2, 18, 1'b1);
  endtask

  task automatic t_modifiers;
    runGlyph("R6 hflip", 3, 8'hF3, 4, 18, 1'b1);
    runGlyph("R7 vflip", 6, 8'h52, 2, 18, 1'b0);
    runGlyph("R7 hvflip", 7, 8'hF9, 3, 18, 1'b1);
    runGlyph("R8 top upper", 1, 8'h53, 4, 18, 1'b0);
    runGlyph("R8 top lower", 1, 8'h54, 12, 18, 1'b0);
    runGlyph("R8 bottom upper", 2, 8'h55, 3, 18, 1'b0);
    runGlyph("R8 bottom lower", 2, 8'h56, 14, 18, 1'b0);
    runGlyph("R9 left", 4, 8'hF2, 8, 18, 1'b1);
    runGlyph("R9 right", 5, 8'hF4, 10, 18, 1'b1);
  endtask

  task automatic t_sticky;
    runGlyph("R10 used", 6, 8'h60, 1, 18, 1'b0);
    runGlyph("R10 cleared after glyph", 0, 8'h61, 1, 18, 1'b0);
    sendNoFetch(8'h06, "R10 first modifier");
    runGlyph("R10 replaced", 3, 8'h62, 1, 18, 1'b0);
  endtask

  task automatic t_ignored;
    scanLine = 6'd2; stripHeight = 6'd18;
    sendNoFetch(8'h06, "R11 modifier");
    sendNoFetch(8'h00, "R11 nop");
    sendNoFetch(8'h10, "R11 code 10h");
    sendNoFetch(8'hE4, "R11 accent");
    sendNoFetch(8'h1F, "R11 code 1Fh");
    sendCode(8'h70);
    check(fetchSlice == 5'd15, "R11 modifier survived", fetchSlice, 15);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_slices();
    t_memsel();
    t_modifiers();
    t_sticky();
    t_ignored();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule